// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. The stream has three wires: a bit clock, a frame clock that marks left and right halves, and a data line. All three are oversampled by the faster system clock. After synchronisation the receiver reads one data bit on each rising edge of the bit clock. It counts bits from the last frame-clock transition to find where each sample sits. It then returns a left and a right 24-bit word together with a single-cycle valid strobe, once per frame.

A 3-bit mode input chooses the framing. Three modes place the sample against the end of each half-frame, at 16, 20 or 24 bits. One mode places a 24-bit sample against the start of the half-frame. The fifth is the common inter-IC sound layout: a 24-bit sample that starts one bit after the frame-clock transition. In that layout a low frame clock marks the left channel. Shorter samples are returned left-aligned, so downstream logic always sees a full-scale two's-complement word.

Top module: `aud_serial_rx`

## Requirements
- R1: Mode codes decode as 0 = 16-bit end-aligned, 1 = 20-bit end-aligned, 2 = 24-bit start-aligned, 3 = 24-bit inter-IC sound, 4 = 24-bit end-aligned. Codes 5, 6 and 7 behave exactly as code 2.
- R2: Data is taken MSB first, one bit per rising bit-clock edge, and is returned as two's complement.
- R3: In the end-aligned modes the sample is the last N bits before the frame clock changes level (N = 16, 20 or 24), and earlier bits of the half-frame are ignored. This works with 16, 20, 24 or 32 bits per half-frame, whenever the half-frame holds at least N bits.
- R4: A 16-bit or 20-bit sample is placed in bits 23 down to 8 (or 23 down to 4) of the output word, and the bits below it are zero.
- R5: In start-aligned mode the MSB is the first bit after the frame-clock transition, the sample is the 24 bits from there, and later bits of the half-frame are ignored.
- R6: In inter-IC sound mode the MSB is the second bit after the frame-clock transition. This also works when the half-frame is exactly 24 bits, in which case the LSB falls on the first bit of the next half.
- R7: The frame clock is high during the left half in modes 0, 1, 2 and 4, and low during the left half in mode 3.
- R8: frame_valid_o is a one-cycle pulse raised once per frame, after the right sample has completed. left_o and right_o change only in the cycle where it is high.
- R9: After reset left_o and right_o are zero and frame_valid_o is low. Nothing is emitted until a frame-clock transition has been seen and a complete left-then-right pair has followed it.
- R10: frame_valid_o goes high no later than 5 system clock cycles after the bit-clock rising edge that completes the right sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Frame format select, changed only while held in reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Frame clock marking left and right halves (asynchronous) |
| sdata_i | input | 1 | Serial data line |
| left_o | output | 24 | Left sample, left-aligned two's complement |
| right_o | output | 24 | Right sample, left-aligned two's complement |
| frame_valid_o | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
A bit counter that is off by one would show up within the first frame as a sample shifted by one bit position. In start-aligned and inter-IC sound modes, it could also show as the wrong number of strobes. A wrong channel-polarity decision shows as swapped words on the very first strobe. A broken left-pending flag shows as a missing or doubled strobe per frame. Synchroniser or edge-detect faults push the strobe past its five-cycle window, or corrupt every bit, so they show at the first frame after lock.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 6;

  typedef enum logic [2:0] {
    FMT_RJ16  = 3'd0,
    FMT_RJ20  = 3'd1,
    FMT_LJ24  = 3'd2,
    FMT_I2S24 = 3'd3,
    FMT_RJ24  = 3'd4
  } fmt_e;

  // Unused codes fall back to the start-aligned format.
  function automatic fmt_e fmt_decode(input logic [2:0] code);
    fmt_e f;
    case (code)
      3'd0:    f = FMT_RJ16;
      3'd1:    f = FMT_RJ20;
      3'd3:    f = FMT_I2S24;
      3'd4:    f = FMT_RJ24;
      default: f = FMT_LJ24;
    endcase
    return f;
  endfunction

  function automatic int unsigned fmt_width(input fmt_e f);
    case (f)
      FMT_RJ16: return 16;
      FMT_RJ20: return 20;
      default:  return SAMPLE_W;
    endcase
  endfunction

  function automatic logic fmt_is_rj(input fmt_e f);
    return (f == FMT_RJ16) || (f == FMT_RJ20) || (f == FMT_RJ24);
  endfunction

  // Frame-clock level that marks the left half.
  function automatic logic fmt_left_level(input fmt_e f);
    return (f != FMT_I2S24);
  endfunction

  // Bit count (1 = first bit after a transition) at which a start-based
  // sample is complete.
  function automatic int unsigned fmt_capture_count(input fmt_e f);
    return (f == FMT_I2S24) ? SAMPLE_W + 1 : SAMPLE_W;
  endfunction

  // Move the newest n bits of the history to the top of the word.
  function automatic logic [SAMPLE_W-1:0] rj_align(input logic [SAMPLE_W-1:0] hist,
                                                   input int unsigned n);
    return hist << (SAMPLE_W - n);
  endfunction

endpackage

// File: rtl/aud_sync.sv
module aud_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/aud_rise_detect.sv
module aud_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/aud_half_capture.sv
module aud_half_capture
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W_P = SAMPLE_W,
  parameter int CNT_W_P    = CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  fmt_e                  fmt_i,
  input  logic                  bit_rise_i,
  input  logic                  lr_i,
  input  logic                  data_i,
  output logic                  half_done_o,
  output logic                  half_left_o,
  output logic [SAMPLE_W_P-1:0] half_data_o
);

  localparam logic [CNT_W_P-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W_P-1:0] CNT_ONE  = CNT_W_P'(1);
  localparam logic [CNT_W_P-1:0] CNT_FULL = CNT_W_P'(SAMPLE_W_P);

  logic [SAMPLE_W_P-1:0] hist_q;
  logic [CNT_W_P-1:0]    cnt_q;
  logic                  lr_prev_q, primed_q, locked_q;

  // Named internal events for the assertions.
  logic                  lr_edge, is_rj, left_lvl;
  logic                  take_rj, take_late, take_mid, take_any;
  logic [SAMPLE_W_P-1:0] hist_next;
  logic [CNT_W_P-1:0]    cnt_inc, cap_cnt;

  assign is_rj     = fmt_is_rj(fmt_i);
  assign left_lvl  = fmt_left_level(fmt_i);
  assign cap_cnt   = CNT_W_P'(fmt_capture_count(fmt_i));
  assign hist_next = {hist_q[SAMPLE_W_P-2:0], data_i};
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
  assign lr_edge   = bit_rise_i && primed_q && (lr_i != lr_prev_q);

  // End-aligned: the half that just closed is in the history.
  assign take_rj   = lr_edge && locked_q && is_rj;
  // Inter-IC sound with exactly 24 bits per half: LSB lands on the edge bit.
  assign take_late = lr_edge && locked_q && (fmt_i == FMT_I2S24) && (cnt_q == CNT_FULL);
  // Start-based formats complete inside the half.
  assign take_mid  = bit_rise_i && !lr_edge && locked_q && !is_rj && (cnt_inc == cap_cnt);
  assign take_any  = take_rj || take_late || take_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      cnt_q     <= '0;
      lr_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      locked_q  <= 1'b0;
    end else if (bit_rise_i) begin
      hist_q    <= hist_next;
      lr_prev_q <= lr_i;
      primed_q  <= 1'b1;
      if (lr_edge) begin
        cnt_q    <= CNT_ONE;
        locked_q <= 1'b1;
      end else begin
        cnt_q    <= cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_done_o <= 1'b0;
      half_left_o <= 1'b0;
      half_data_o <= '0;
    end else begin
      half_done_o <= take_any;
      if (take_rj) begin
        half_data_o <= rj_align(hist_q, fmt_width(fmt_i));
        half_left_o <= (lr_prev_q == left_lvl);
      end else if (take_late) begin
        half_data_o <= hist_next;
        half_left_o <= (lr_prev_q == left_lvl);
      end else if (take_mid) begin
        half_data_o <= hist_next;
        half_left_o <= (lr_i == left_lvl);
      end
    end
  end

  // R2: a finished sample always follows a bit-clock rising edge.
  p_done_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_done_o |-> $past(bit_rise_i));

  // R3: end-aligned samples are closed by a frame-clock transition.
  p_rj_closed_by_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_done_o && $past(is_rj)) |-> (cnt_q == CNT_ONE));

  // R9: nothing is captured before the first transition has been seen.
  p_no_take_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    half_done_o |-> $past(locked_q));

endmodule

// File: rtl/aud_frame_pair.sv
module aud_frame_pair #(
  parameter int SAMPLE_W_P = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  half_done_i,
  input  logic                  half_left_i,
  input  logic [SAMPLE_W_P-1:0] half_data_i,
  output logic [SAMPLE_W_P-1:0] left_o,
  output logic [SAMPLE_W_P-1:0] right_o,
  output logic                  frame_valid_o
);

  logic [SAMPLE_W_P-1:0] hold_q;
  logic                  have_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q        <= '0;
      have_left_q   <= 1'b0;
      left_o        <= '0;
      right_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      frame_valid_o <= 1'b0;
      if (half_done_i) begin
        if (half_left_i) begin
          hold_q      <= half_data_i;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o        <= hold_q;
          right_o       <= half_data_i;
          frame_valid_o <= 1'b1;
          have_left_q   <= 1'b0;
        end
      end
    end
  end

  // R8: the strobe lasts one cycle.
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |=> !frame_valid_o);

  // R8: the outputs move only together with the strobe.
  p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R8: a strobe is caused by a completed right sample.
  p_valid_after_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> $past(half_done_i && !half_left_i));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W_P    = SAMPLE_W,
  parameter int CNT_W_P       = CNT_W,
  parameter int SYNC_STAGES_P = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            mode_i,
  input  logic                  bclk_i,
  input  logic                  lrck_i,
  input  logic                  sdata_i,
  output logic [SAMPLE_W_P-1:0] left_o,
  output logic [SAMPLE_W_P-1:0] right_o,
  output logic                  frame_valid_o
);

  localparam int NUM_LINES = 3;

  fmt_e                  fmt;
  logic [NUM_LINES-1:0]  lines_s;
  logic                  bclk_s, lrck_s, sdata_s, bit_rise;
  logic                  half_done, half_left;
  logic [SAMPLE_W_P-1:0] half_data;

  assign fmt = fmt_decode(mode_i);

  // All three lines share one synchroniser so their skew is preserved.
  aud_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES_P)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({bclk_i, lrck_i, sdata_i}),
    .sync_o  (lines_s)
  );
  assign {bclk_s, lrck_s, sdata_s} = lines_s;

  aud_rise_detect u_bclk_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (bclk_s),
    .rise_o  (bit_rise)
  );

  aud_half_capture #(.SAMPLE_W_P(SAMPLE_W_P), .CNT_W_P(CNT_W_P)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_i       (fmt),
    .bit_rise_i  (bit_rise),
    .lr_i        (lrck_s),
    .data_i      (sdata_s),
    .half_done_o (half_done),
    .half_left_o (half_left),
    .half_data_o (half_data)
  );

  aud_frame_pair #(.SAMPLE_W_P(SAMPLE_W_P)) u_pair (
    .clk           (clk),
    .rst_n         (rst_n),
    .half_done_i   (half_done),
    .half_left_i   (half_left),
    .half_data_i   (half_data),
    .left_o        (left_o),
    .right_o       (right_o),
    .frame_valid_o (frame_valid_o)
  );

  // R4: 16-bit samples leave the low byte clear.
  p_rj16_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_o && fmt == FMT_RJ16) |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00));

  // R4: 20-bit samples leave the low nibble clear.
  p_rj20_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_o && fmt == FMT_RJ20) |-> (left_o[3:0] == 4'h0 && right_o[3:0] == 4'h0));

endmodule

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd2;
  logic        bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        frame_valid_o;

  int errors = 0, checks = 0;
  int cyc = 0, last_rise = 0;
  int rec_n = 0, max_lat = 0;
  bit done = 0;
  logic [23:0] rec_l [8];
  logic [23:0] rec_r [8];

  always #4 clk = ~clk;  // 125 MHz

  aud_serial_rx u_aud_serial_rx (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bclk_i(bclk), .lrck_i(lrck),
    .sdata_i(sdata), .left_o(left_o), .right_o(right_o), .frame_valid_o(frame_valid_o)
  );

  always @(posedge clk) cyc = cyc + 1;

  // Monitor: records every strobe and its distance from the last bit-clock rise.
  always @(negedge clk) begin
    if (!rst_n) begin
      rec_n = 0;
      max_lat = 0;
    end else if (frame_valid_o) begin
      if (rec_n < 8) begin
        rec_l[rec_n] = left_o;
        rec_r[rec_n] = right_o;
      end
      rec_n = rec_n + 1;
      if (cyc - last_rise > max_lat) max_lat = cyc - last_rise;
    end
  end

  // {mode[2:0], bits per half[6:0], left seed[23:0], right seed[23:0]}
  localparam int NVEC = 12;
  localparam logic [57:0] VEC [NVEC] = '{
    {3'd0, 7'd16, 24'h8123F7, 24'h7E5A11},
    {3'd0, 7'd32, 24'h12AB34, 24'hF0F0C3},
    {3'd1, 7'd20, 24'hA5C3E9, 24'h3C1D77},
    {3'd1, 7'd32, 24'h7FFFFF, 24'h800001},
    {3'd2, 7'd24, 24'h9ABCDE, 24'h13579B},
    {3'd2, 7'd32, 24'hC0FFEE, 24'h0BADF0},
    {3'd3, 7'd32, 24'h89ABCD, 24'h456701},
    {3'd3, 7'd24, 24'hE13579, 24'h2468AC},
    {3'd4, 7'd24, 24'hF00D5A, 24'h1E2D3C},
    {3'd4, 7'd32, 24'h800000, 24'h000001},
    {3'd6, 7'd32, 24'hDEAD01, 24'h5EED02},
    {3'd7, 7'd24, 24'h313131, 24'hCECECE}
  };

  function automatic int eff_mode(input logic [2:0] m);
    return (m > 3'd4) ? 2 : int'(m);
  endfunction

  function automatic int width_of(input int em);
    return (em == 0) ? 16 : (em == 1) ? 20 : 24;
  endfunction

  // Expected word: only the top n bits of the seed survive.
  function automatic logic [23:0] keep_top(input logic [23:0] raw, input int n);
    logic [23:0] r;
    r = raw;
    for (int i = 0; i < 24 - n; i++) r[i] = 1'b0;
    return r;
  endfunction

  function automatic string tag_of(input int em, input logic [2:0] m);
    string t;
    case (em)
      2:       t = "R5";
      3:       t = "R6";
      default: t = "R3/R4";
    endcase
    if (m > 3'd4) t = {t, "/R1"};
    return {t, "/R2/R7"};
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic lr, input logic d);
    @(posedge clk); #1;
    bclk = 1'b0; lrck = lr; sdata = d;
    repeat (4) @(posedge clk);
    #1 bclk = 1'b1;
    last_rise = cyc;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_half(input logic lr, input int em, input int bpf,
                           input logic [23:0] raw, inout logic carry);
    int n;
    n = width_of(em);
    for (int k = 0; k < bpf; k++) begin
      logic b;
      b = k[0];  // filler that must be ignored
      if (em == 2) begin
        if (k < 24) b = raw[23-k];
      end else if (em == 3) begin
        if (k == 0) b = carry;
        else if (k <= 24) b = raw[24-k];
      end else begin
        if (k >= bpf - n) b = raw[23-(k-(bpf-n))];
      end
      send_bit(lr, b);
    end
    carry = (em == 3 && bpf == 24) ? raw[0] : 1'b1;
  endtask

  task automatic do_reset(input logic [2:0] m, input logic idle_lr);
    #1 rst_n = 1'b0;
    mode = m; bclk = 1'b0; lrck = idle_lr; sdata = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state.
    do_reset(3'd2, 1'b0);
    @(negedge clk);
    check(left_o == 24'h0 && right_o == 24'h0, "R9 reset data",
          {left_o, right_o}, 48'h0);
    check(frame_valid_o == 1'b0, "R9 reset strobe", {47'h0, frame_valid_o}, 48'h0);

    // R9: no transition on the frame clock means no output.
    for (int k = 0; k < 40; k++) send_bit(1'b1, k[1]);
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(rec_n == 0 && left_o == 24'h0, "R9 no lock no output",
          {24'(rec_n), left_o}, 48'h0);

    // Vector table: three frames per format plus a closing half.
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] m;
      int em, bpf, n;
      logic lvl, carry;
      logic [23:0] sl, sr;
      logic [23:0] fl [3];
      logic [23:0] fr [3];
      m   = VEC[v][57:55];
      bpf = int'(VEC[v][54:48]);
      sl  = VEC[v][47:24];
      sr  = VEC[v][23:0];
      em  = eff_mode(m);
      n   = width_of(em);
      lvl = (em == 3) ? 1'b0 : 1'b1;  // R7: left-half level
      carry = 1'b1;
      do_reset(m, ~lvl);
      send_bit(~lvl, 1'b0);
      send_bit(~lvl, 1'b1);
      for (int f = 0; f < 3; f++) begin
        fl[f] = sl + 24'(f) * 24'h0A3B17;
        fr[f] = sr - 24'(f) * 24'h05C1E3;
        send_half(lvl, em, bpf, fl[f], carry);
        send_half(~lvl, em, bpf, fr[f], carry);
      end
      send_half(lvl, em, bpf, 24'h000000, carry);
      repeat (10) @(posedge clk);
      @(negedge clk);
      // R8: one strobe per frame.
      check(rec_n == 3, $sformatf("R8 strobes vec%0d", v), 48'(rec_n), 48'd3);
      for (int f = 0; f < 3; f++) begin
        logic [23:0] el, er;
        el = keep_top(fl[f], n);
        er = keep_top(fr[f], n);
        check(rec_l[f] == el && rec_r[f] == er,
              $sformatf("%s vec%0d frame%0d", tag_of(em, m), v, f),
              {rec_l[f], rec_r[f]}, {el, er});
      end
      // R10: strobe latency after the completing bit-clock edge.
      check(max_lat <= 5 && max_lat > 0, $sformatf("R10 latency vec%0d", v),
            48'(max_lat), 48'd5);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule